// File: doc/BRIEF.md
# Polled Keyboard Input Port

A peripheral interface that lets a 16-bit processor read characters from a key source through two bus addresses. A key-strobe side offers an 8-bit character code qualified by a one-cycle valid pulse. The port latches the first character it sees, raises a ready flag, and then ignores further keystrokes until software takes the character by reading the character register. Software can either poll the status word for the ready flag or enable an interrupt request that follows the flag.

On the processor side the block decodes a 16-bit address with read and write strobes. During a read of one of its two addresses it returns the register value combinationally and raises a select that tells the memory data register to load device data instead of memory data. Register state changes on the rising clock edge.

Top module: `kbd_input_port`

## Requirements
- R1: A read at 0xFE00 returns the status word and a read at 0xFE02 returns the character word, both with `dev_sel` high in the same cycle; a read of any other address gives `dev_sel` low and `bus_rdata` zero.
- R2: A key strobe while the ready flag is clear stores the code; from the next cycle the character word reads with the code in bits [7:0] and zero in bits [15:8], and status bit 15 (ready) reads one.
- R3: While the ready flag is set, key strobes are dropped and the stored character stays unchanged.
- R4: A read of the character word clears the ready flag at the next edge and re-enables capture; a read of the status word leaves the flag unchanged.
- R5: A write to 0xFE00 loads status bit 14 (interrupt enable) from write-data bit 14, readable in the status word.
- R6: `irq` is high exactly when both the ready flag and the interrupt-enable bit are one.
- R7: Writes cannot change the ready flag or the character word, and status bits [13:0] always read zero.
- R8: When a key strobe and a character-word read fall in the same cycle, the read returns the old character, the ready flag ends clear and the new code is dropped.
- R9: Reset clears the ready flag, the interrupt-enable bit and the character word, leaving capture enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_code | input | 8 | Character code from the key source |
| key_valid | input | 1 | One-cycle strobe qualifying `key_code` |
| bus_addr | input | 16 | Processor bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `dev_sel` is high |
| dev_sel | output | 1 | High when read data must come from this port, not memory |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or wrongly set ready flag shows up on the next status read and on `irq` one cycle after the event that should have changed it, and also as a capture that happens or fails to happen on the following key strobe. A wrongly latched character appears on the very next character-word read. Interrupt-enable corruption is visible on `irq` immediately while a character is pending, and on any status read otherwise; the bench therefore reads back status after every state-changing operation.

// File: rtl/kbdp_pkg.sv
package kbdp_pkg;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned CHAR_W = 8;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CHAR = 2'd2
   } reg_sel_e;

   function automatic logic [DATA_W-1:0] bit_at(input int unsigned pos, input logic val);
      logic [DATA_W-1:0] w;
      w = '0;
      w[pos] = val;
      return w;
   endfunction
endpackage

// File: rtl/kbdp_addr_dec.sv
module kbdp_addr_dec #(
   parameter int unsigned             ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]       STAT_ADDR = 16'hFE00,
   parameter logic [ADDR_W-1:0]       CHAR_ADDR = 16'hFE02
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output kbdp_pkg::reg_sel_e rd_sel,
   output logic              stat_wr
);
   import kbdp_pkg::*;

   initial begin
      if (STAT_ADDR == CHAR_ADDR) $error("status and character addresses must differ");
   end

   always_comb begin
      rd_sel = SEL_NONE;
      if (rd) begin
         if (addr == STAT_ADDR)      rd_sel = SEL_STAT;
         else if (addr == CHAR_ADDR) rd_sel = SEL_CHAR;
      end
   end

   assign stat_wr = wr && (addr == STAT_ADDR);
endmodule

// File: rtl/kbdp_regs.sv
module kbdp_regs #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] key_code,
   input  logic              key_valid,
   input  logic              char_rd,
   input  logic              stat_wr,
   input  logic              ie_wbit,
   output logic              rdy_q,
   output logic              ie_q,
   output logic [CHAR_W-1:0] char_q
);
   logic capture;

   // read of the character word has priority over an arriving key
   assign capture = key_valid && !rdy_q && !char_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q  <= 1'b0;
         char_q <= '0;
      end else if (char_rd) begin
         rdy_q  <= 1'b0;
      end else if (capture) begin
         rdy_q  <= 1'b1;
         char_q <= key_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ie_q <= 1'b0;
      else if (stat_wr) ie_q <= ie_wbit;
   end
endmodule

// File: rtl/kbdp_rd_mux.sv
module kbdp_rd_mux #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned RDY_BIT = 15,
   parameter int unsigned IE_BIT  = 14
) (
   input  kbdp_pkg::reg_sel_e rd_sel,
   input  logic               rdy,
   input  logic               ie,
   input  logic [CHAR_W-1:0]  char_val,
   output logic [DATA_W-1:0]  rdata,
   output logic               dev_sel
);
   import kbdp_pkg::*;

   localparam int unsigned PAD_W = DATA_W - CHAR_W;

   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] char_word;

   always_comb begin
      stat_word = '0;
      stat_word[RDY_BIT] = rdy;
      stat_word[IE_BIT]  = ie;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign char_word = {{PAD_W{1'b0}}, char_val};
      end else begin : g_nopad
         assign char_word = char_val;
      end
   endgenerate

   always_comb begin
      unique case (rd_sel)
         SEL_STAT: rdata = stat_word;
         SEL_CHAR: rdata = char_word;
         default:  rdata = '0;
      endcase
   end

   assign dev_sel = (rd_sel != SEL_NONE);
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port #(
   parameter int unsigned         ADDR_W    = 16,
   parameter int unsigned         DATA_W    = 16,
   parameter int unsigned         CHAR_W    = 8,
   parameter logic [ADDR_W-1:0]   STAT_ADDR = 16'hFE00,
   parameter logic [ADDR_W-1:0]   CHAR_ADDR = 16'hFE02,
   parameter int unsigned         RDY_BIT   = 15,
   parameter int unsigned         IE_BIT    = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] key_code,
   input  logic              key_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              dev_sel,
   output logic              irq
);
   import kbdp_pkg::*;

   initial begin
      if (CHAR_W > DATA_W)   $error("character wider than data word");
      if (RDY_BIT >= DATA_W) $error("ready bit outside data word");
      if (IE_BIT >= DATA_W)  $error("enable bit outside data word");
      if (RDY_BIT == IE_BIT) $error("ready and enable bits collide");
   end

   reg_sel_e          rd_sel;
   logic              stat_wr;
   logic              rdy_q;
   logic              ie_q;
   logic [CHAR_W-1:0] char_q;

   kbdp_addr_dec #(
      .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CHAR_ADDR(CHAR_ADDR)
   ) dec_i (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .rd_sel(rd_sel), .stat_wr(stat_wr)
   );

   kbdp_regs #(.CHAR_W(CHAR_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .key_code(key_code), .key_valid(key_valid),
      .char_rd(rd_sel == SEL_CHAR), .stat_wr(stat_wr),
      .ie_wbit(bus_wdata[IE_BIT]),
      .rdy_q(rdy_q), .ie_q(ie_q), .char_q(char_q)
   );

   kbdp_rd_mux #(
      .DATA_W(DATA_W), .CHAR_W(CHAR_W), .RDY_BIT(RDY_BIT), .IE_BIT(IE_BIT)
   ) mux_i (
      .rd_sel(rd_sel), .rdy(rdy_q), .ie(ie_q), .char_val(char_q),
      .rdata(bus_rdata), .dev_sel(dev_sel)
   );

   assign irq = rdy_q & ie_q;
endmodule

// File: rtl/kbd_input_port_chk.sv
module kbd_input_port_chk #(
   parameter int unsigned         ADDR_W    = 16,
   parameter int unsigned         DATA_W    = 16,
   parameter int unsigned         CHAR_W    = 8,
   parameter logic [ADDR_W-1:0]   STAT_ADDR = 16'hFE00,
   parameter logic [ADDR_W-1:0]   CHAR_ADDR = 16'hFE02
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CHAR_W-1:0] key_code,
   input logic              key_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              dev_sel,
   input logic              irq,
   input logic              rdy_q,
   input logic [CHAR_W-1:0] char_q
);
   logic char_rd;
   logic stat_rd;
   assign char_rd = bus_rd && (bus_addr == CHAR_ADDR);
   assign stat_rd = bus_rd && (bus_addr == STAT_ADDR);

   // R1
   sel_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_sel |-> (char_rd || stat_rd));

   // R1
   idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_sel |-> (bus_rdata == '0));

   // R2
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && !rdy_q && !char_rd) |=> (rdy_q && char_q == $past(key_code)));

   // R3
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |=> $stable(char_q));

   // R4
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_rd |=> !rdy_q);

   // R6
   irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rdy_q);

   // R7
   write_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rd && !key_valid) |=> (rdy_q == $past(rdy_q)));

   // R8
   read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && char_rd) |=> (!rdy_q && $stable(char_q)));
endmodule

bind kbd_input_port kbd_input_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
   .STAT_ADDR(STAT_ADDR), .CHAR_ADDR(CHAR_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_valid(key_valid),
   .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_rdata(bus_rdata), .dev_sel(dev_sel), .irq(irq),
   .rdy_q(rdy_q), .char_q(char_q)
);

// File: tb/kbd_input_port_tb.sv
`timescale 1ns/1ps
module kbd_input_port_tb_top;
   localparam logic [15:0] A_STAT = 16'hFE00;
   localparam logic [15:0] A_CHAR = 16'hFE02;

   // op codes
   localparam logic [2:0] OP_IDLE = 3'd0, OP_KEY = 3'd1, OP_RSTAT = 3'd2, OP_RCHAR = 3'd3,
                          OP_WSTAT = 3'd4, OP_WCHAR = 3'd5, OP_KEYRD = 3'd6, OP_ROTHER = 3'd7;

   // {req[3:0], op[2:0], arg[15:0], exp_rdata[15:0], exp_irq}
   localparam int NV = 19;
   localparam logic [39:0] VEC [NV] = '{
      {4'd9, OP_RSTAT,  16'h0000, 16'h0000, 1'b0}, // R9 reset state
      {4'd2, OP_KEY,    16'h0041, 16'h0000, 1'b0}, // R2 capture
      {4'd2, OP_RSTAT,  16'h0000, 16'h8000, 1'b0}, // R2 ready set
      {4'd3, OP_KEY,    16'h0042, 16'h0000, 1'b0}, // R3 dropped
      {4'd7, OP_WCHAR,  16'h1234, 16'h0000, 1'b0}, // R7 write ignored
      {4'd3, OP_RCHAR,  16'h0000, 16'h0041, 1'b0}, // R3 first char kept
      {4'd4, OP_RSTAT,  16'h0000, 16'h0000, 1'b0}, // R4 ready cleared
      {4'd5, OP_WSTAT,  16'hFFFF, 16'h0000, 1'b0}, // R5 enable, R7 ready untouched
      {4'd7, OP_RSTAT,  16'h0000, 16'h4000, 1'b0}, // R7 low bits zero
      {4'd6, OP_KEY,    16'h005A, 16'h0000, 1'b1}, // R6 irq on
      {4'd4, OP_RSTAT,  16'h0000, 16'hC000, 1'b1}, // R4 status read keeps flag
      {4'd4, OP_RCHAR,  16'h0000, 16'h005A, 1'b0}, // R4 read clears
      {4'd8, OP_KEYRD,  16'h0033, 16'h005A, 1'b0}, // R8 read wins
      {4'd8, OP_RSTAT,  16'h0000, 16'h4000, 1'b0}, // R8 flag clear
      {4'd1, OP_ROTHER, 16'hFE04, 16'h0000, 1'b0}, // R1 foreign address
      {4'd5, OP_WSTAT,  16'h0000, 16'h0000, 1'b0}, // R5 disable
      {4'd6, OP_KEY,    16'h007E, 16'h0000, 1'b0}, // R6 ready w/o enable
      {4'd6, OP_WSTAT,  16'h4000, 16'h0000, 1'b1}, // R6 enable raises irq
      {4'd1, OP_RCHAR,  16'h0000, 16'h007E, 1'b0}  // R1 char read
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  key_code = '0;
   logic        key_valid = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        dev_sel;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   kbd_input_port dut_i (
      .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_valid(key_valid),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .dev_sel(dev_sel), .irq(irq)
   );

   task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [15:0] arg);
      key_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; key_code = '0;
      case (op)
         OP_KEY:    begin key_valid = 1'b1; key_code = arg[7:0]; end
         OP_RSTAT:  begin bus_rd = 1'b1; bus_addr = A_STAT; end
         OP_RCHAR:  begin bus_rd = 1'b1; bus_addr = A_CHAR; end
         OP_WSTAT:  begin bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = arg; end
         OP_WCHAR:  begin bus_wr = 1'b1; bus_addr = A_CHAR; bus_wdata = arg; end
         OP_KEYRD:  begin key_valid = 1'b1; key_code = arg[7:0]; bus_rd = 1'b1; bus_addr = A_CHAR; end
         OP_ROTHER: begin bus_rd = 1'b1; bus_addr = arg; end
         default: ;
      endcase
   endtask

   // one operation: drive at negedge, sample combinational read, settle, sample irq
   task automatic apply(input int req, input logic [2:0] op, input logic [15:0] arg,
                        input logic [15:0] exp_rd, input logic exp_irq);
      logic is_rd;
      @(negedge clk);
      drive(op, arg);
      #1;
      is_rd = (op == OP_RSTAT) || (op == OP_RCHAR) || (op == OP_KEYRD) || (op == OP_ROTHER);
      if (is_rd) begin
         check(req, "rdata", bus_rdata, exp_rd);
         check(req, "dev_sel", {15'd0, dev_sel}, {15'd0, op != OP_ROTHER});
      end
      @(negedge clk);
      drive(OP_IDLE, '0);
      #1;
      check(req, "irq", {15'd0, irq}, {15'd0, exp_irq});
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1;
      // R9 outputs during reset
      check(9, "irq in reset", {15'd0, irq}, 16'd0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++)
         apply(int'(VEC[i][39:36]), VEC[i][35:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0]);

      // R9 reset mid-run clears pending char and enable
      apply(5, OP_WSTAT, 16'h4000, 16'h0000, 1'b0);
      apply(6, OP_KEY, 16'h0061, 16'h0000, 1'b1);
      @(negedge clk) rst_n = 1'b0;
      #1 check(9, "irq after reset", {15'd0, irq}, 16'd0);
      @(negedge clk) rst_n = 1'b1;
      apply(9, OP_RSTAT, 16'h0000, 16'h0000, 1'b0);
      apply(9, OP_RCHAR, 16'h0000, 16'h0000, 1'b0);
      apply(9, OP_KEY, 16'h0062, 16'h0000, 1'b0);
      apply(9, OP_RCHAR, 16'h0000, 16'h0062, 1'b0);

      // R4 capture right after the clearing read
      apply(2, OP_KEY, 16'h0070, 16'h0000, 1'b0);
      apply(4, OP_RCHAR, 16'h0000, 16'h0070, 1'b0);
      apply(4, OP_KEY, 16'h00FF, 16'h0000, 1'b0);
      apply(2, OP_RCHAR, 16'h0000, 16'h00FF, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule